// File: doc/BRIEF.md
# Tournament Direction Chooser

This block arbitrates between two conditional-branch direction predictors that both produce a guess for the same branch: a per-address predictor (bimodal or local-history) and a global-history predictor. It holds a table of small per-entry selector states. On the prediction side it combines the branch address or the global history with the two component guesses. It returns the final direction, the component it trusted, and the table index it used. On the resolution side the pipeline hands back that index, both component guesses and the real outcome, and the selected entry is trained.

The table index is formed from the low bits of either the branch address or the global history, under control of a configuration input. A build-time parameter picks one of two entry formats. The saturating-counter form shifts only when the two components disagreed in correctness. The flag form remembers, per entry, whether each component was right the last time and trusts the per-address side only when it alone was right. The component predictors themselves are not part of the block.

Top module: `tournament_chooser`

## Requirements
- R1: With `idx_by_hist` = 0, `pred_idx` equals the low IDX_W bits of `pred_addr`; with `idx_by_hist` = 1 it equals the low IDX_W bits of `pred_hist`.
- R2: `final_pred` equals `loc_pred` while `pick_local` is 1, and `glb_pred` while it is 0.
- R3: Counter style: after reset every entry holds 01, so `pick_local` is 0 (global) for every index; `pick_local` is the entry's upper bit.
- R4: Counter style: a resolve where the per-address guess matched `res_taken` and the global guess did not adds one to the entry, saturating at 11.
- R5: Counter style: a resolve where the global guess matched `res_taken` and the per-address guess did not subtracts one, saturating at 00.
- R6: Counter style: a resolve where both guesses were right, or both wrong, leaves the entry unchanged.
- R7: Flag style: after reset both flags of every entry are clear, so `pick_local` is 0 everywhere.
- R8: Flag style: each resolve overwrites the entry with the correctness of each component; `pick_local` is 1 only when the per-address flag is set and the global flag is clear.
- R9: Training writes the entry at `res_idx` whatever `idx_by_hist`, `pred_addr` or `pred_hist` are in that cycle.
- R10: A prediction and a resolve on the same entry in one cycle: the prediction reflects the entry before the update; the updated value is seen from the next clock edge on.
- R11: With `res_valid` low no entry changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_by_hist | input | 1 | 0: index from address bits, 1: index from global history |
| pred_addr | input | ADDR_W | Branch address at prediction |
| pred_hist | input | HIST_W | Global history at prediction |
| loc_pred | input | 1 | Per-address component guess (1 = taken) |
| glb_pred | input | 1 | Global component guess (1 = taken) |
| pred_idx | output | IDX_W | Table index used, to be carried to resolution |
| pick_local | output | 1 | 1: per-address component chosen, 0: global chosen |
| final_pred | output | 1 | Chosen direction |
| res_valid | input | 1 | Resolve strobe |
| res_idx | input | IDX_W | Index captured at prediction |
| res_loc_pred | input | 1 | Per-address guess made at prediction |
| res_glb_pred | input | 1 | Global guess made at prediction |
| res_taken | input | 1 | Actual outcome |

## Verification
The lookup of an entry for a new branch and the training of that same entry by a resolving branch can occur in one cycle. The bench provokes this by presenting a prediction at the index it resolves, with a training outcome that flips the choice. It judges the cycle before the edge (old choice expected) and the cycle after it (new choice expected) for both entry formats. Saturation is judged through the number of opposite updates needed before the choice flips.

// File: rtl/tc_pkg.sv
package tc_pkg;
   localparam int STYLE_COUNTER = 0;
   localparam int STYLE_FLAGS   = 1;

   localparam logic [1:0] CTR_WEAK_GLOBAL = 2'b01;
   localparam logic [1:0] FLAGS_CLEAR     = 2'b00;

   typedef logic [1:0] tc_entry_t;

   function automatic tc_entry_t ctr_step(input tc_entry_t cur, input logic up, input logic dn);
      tc_entry_t nxt;
      nxt = cur;
      if (up && !dn && cur != 2'b11) nxt = cur + 2'b01;
      else if (dn && !up && cur != 2'b00) nxt = cur - 2'b01;
      return nxt;
   endfunction
endpackage

// File: rtl/tc_index_mux.sv
module tc_index_mux #(
   parameter int IDX_W  = 6,
   parameter int ADDR_W = 16,
   parameter int HIST_W = 12
) (
   input  logic              use_hist,
   input  logic [ADDR_W-1:0] addr,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      if (use_hist) idx = hist[IDX_W-1:0];
      else          idx = addr[IDX_W-1:0];
   end
endmodule

// File: rtl/tc_entry_table.sv
module tc_entry_table
   import tc_pkg::*;
#(
   parameter int        IDX_W = 6,
   parameter tc_entry_t INIT  = CTR_WEAK_GLOBAL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output tc_entry_t        rd_ent,
   input  logic [IDX_W-1:0] up_idx,
   output tc_entry_t        up_old,
   input  logic             wr_en,
   input  tc_entry_t        wr_ent
);
   localparam int DEPTH = 1 << IDX_W;

   tc_entry_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      end else if (wr_en) begin
         mem[up_idx] <= wr_ent;
      end
   end

   assign rd_ent = mem[rd_idx];
   assign up_old = mem[up_idx];
endmodule

// File: rtl/tc_train.sv
module tc_train
   import tc_pkg::*;
#(
   parameter int STYLE = STYLE_COUNTER
) (
   input  tc_entry_t old_ent,
   input  logic      loc_ok,
   input  logic      glb_ok,
   output tc_entry_t new_ent
);
   generate
      if (STYLE == STYLE_COUNTER) begin : g_ctr
         always_comb new_ent = ctr_step(old_ent, loc_ok & ~glb_ok, glb_ok & ~loc_ok);
      end else begin : g_flags
         logic unused_old;
         assign unused_old = ^old_ent;
         always_comb new_ent = {loc_ok, glb_ok};
      end
   endgenerate
endmodule

// File: rtl/tc_pick.sv
module tc_pick
   import tc_pkg::*;
#(
   parameter int STYLE = STYLE_COUNTER
) (
   input  tc_entry_t ent,
   output logic      use_local
);
   generate
      if (STYLE == STYLE_COUNTER) begin : g_ctr
         assign use_local = ent[1];
      end else begin : g_flags
         assign use_local = ent[1] & ~ent[0];
      end
   endgenerate
endmodule

// File: rtl/tournament_chooser.sv
module tournament_chooser
   import tc_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int ADDR_W = 16,
   parameter int HIST_W = 12,
   parameter int STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_by_hist,
   input  logic [ADDR_W-1:0] pred_addr,
   input  logic [HIST_W-1:0] pred_hist,
   input  logic              loc_pred,
   input  logic              glb_pred,
   output logic [IDX_W-1:0]  pred_idx,
   output logic              pick_local,
   output logic              final_pred,
   input  logic              res_valid,
   input  logic [IDX_W-1:0]  res_idx,
   input  logic              res_loc_pred,
   input  logic              res_glb_pred,
   input  logic              res_taken
);
   localparam tc_entry_t INIT = (STYLE == STYLE_COUNTER) ? CTR_WEAK_GLOBAL : FLAGS_CLEAR;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("tournament_chooser: IDX_W must be 1..12");
      end
      if (ADDR_W < IDX_W || HIST_W < IDX_W) begin : g_bad_src
         $error("tournament_chooser: ADDR_W and HIST_W must be >= IDX_W");
      end
      if (STYLE != STYLE_COUNTER && STYLE != STYLE_FLAGS) begin : g_bad_style
         $error("tournament_chooser: STYLE must be 0 or 1");
      end
   endgenerate

   tc_entry_t rd_ent, old_ent, new_ent;
   logic      loc_ok, glb_ok;

   assign loc_ok = (res_loc_pred == res_taken);
   assign glb_ok = (res_glb_pred == res_taken);

   tc_index_mux #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_idx (
      .use_hist (idx_by_hist),
      .addr     (pred_addr),
      .hist     (pred_hist),
      .idx      (pred_idx)
   );

   tc_entry_table #(.IDX_W(IDX_W), .INIT(INIT)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_idx),
      .rd_ent (rd_ent),
      .up_idx (res_idx),
      .up_old (old_ent),
      .wr_en  (res_valid),
      .wr_ent (new_ent)
   );

   tc_train #(.STYLE(STYLE)) u_train (
      .old_ent (old_ent),
      .loc_ok  (loc_ok),
      .glb_ok  (glb_ok),
      .new_ent (new_ent)
   );

   tc_pick #(.STYLE(STYLE)) u_pick (
      .ent       (rd_ent),
      .use_local (pick_local)
   );

   assign final_pred = pick_local ? loc_pred : glb_pred;
endmodule

// File: rtl/tournament_chooser_chk.sv
module tournament_chooser_chk #(
   parameter int IDX_W = 6,
   parameter int STYLE = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loc_pred,
   input logic             glb_pred,
   input logic [IDX_W-1:0] pred_idx,
   input logic             pick_local,
   input logic             final_pred,
   input logic             res_valid,
   input logic [IDX_W-1:0] res_idx,
   input logic             res_loc_pred,
   input logic             res_glb_pred,
   input logic             res_taken
);
   logic seen_res;
   always_ff @(posedge clk) begin
      if (!rst_n)         seen_res <= 1'b0;
      else if (res_valid) seen_res <= 1'b1;
   end

   // R2
   a_r2_follow_choice: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (final_pred == (pick_local ? loc_pred : glb_pred)));

   // R3 / R7
   a_r3_r7_reset_global: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_res |-> !pick_local);

   // R11
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_res && !$past(res_valid) && $stable(pred_idx)) |-> $stable(pick_local));

   generate
      if (STYLE == 0) begin : g_ctr
         // R6
         a_r6_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(res_valid) && $past(res_loc_pred == res_glb_pred) && $stable(pred_idx))
            |-> $stable(pick_local));
         // R4
         a_r4_up_keeps_local: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(res_valid && res_loc_pred == res_taken && res_glb_pred != res_taken)
             && $past(pick_local) && $stable(pred_idx) && pred_idx == $past(res_idx))
            |-> pick_local);
      end else begin : g_flags
         // R8
         a_r8_flag_local: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(res_valid && res_loc_pred == res_taken && res_glb_pred != res_taken)
             && pred_idx == $past(res_idx)) |-> pick_local);
         a_r8_flag_global: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(res_valid && res_glb_pred == res_taken) && pred_idx == $past(res_idx))
            |-> !pick_local);
      end
   endgenerate
endmodule

bind tournament_chooser tournament_chooser_chk #(.IDX_W(IDX_W), .STYLE(STYLE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .loc_pred     (loc_pred),
   .glb_pred     (glb_pred),
   .pred_idx     (pred_idx),
   .pick_local   (pick_local),
   .final_pred   (final_pred),
   .res_valid    (res_valid),
   .res_idx      (res_idx),
   .res_loc_pred (res_loc_pred),
   .res_glb_pred (res_glb_pred),
   .res_taken    (res_taken)
);

// File: tb/tournament_chooser_tb.sv
`timescale 1ns/1ps
module tournament_chooser_tb;
   localparam int IDX_W = 6, ADDR_W = 16, HIST_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic idx_by_hist = 1'b0;
   logic [ADDR_W-1:0] pred_addr = '0;
   logic [HIST_W-1:0] pred_hist = '0;
   logic loc_pred = 1'b0, glb_pred = 1'b0;
   logic res_valid = 1'b0, res_loc_pred = 1'b0, res_glb_pred = 1'b0, res_taken = 1'b0;
   logic [IDX_W-1:0] res_idx = '0;
   logic [IDX_W-1:0] idx_c, idx_f;
   logic pick_c, pick_f, fin_c, fin_f;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tournament_chooser #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .idx_by_hist(idx_by_hist), .pred_addr(pred_addr),
      .pred_hist(pred_hist), .loc_pred(loc_pred), .glb_pred(glb_pred), .pred_idx(idx_c),
      .pick_local(pick_c), .final_pred(fin_c), .res_valid(res_valid), .res_idx(res_idx),
      .res_loc_pred(res_loc_pred), .res_glb_pred(res_glb_pred), .res_taken(res_taken));

   tournament_chooser #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .STYLE(1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .idx_by_hist(idx_by_hist), .pred_addr(pred_addr),
      .pred_hist(pred_hist), .loc_pred(loc_pred), .glb_pred(glb_pred), .pred_idx(idx_f),
      .pick_local(pick_f), .final_pred(fin_f), .res_valid(res_valid), .res_idx(res_idx),
      .res_loc_pred(res_loc_pred), .res_glb_pred(res_glb_pred), .res_taken(res_taken));

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // look up an index via the address path, sample mid low phase
   task automatic look(input int idx);
      @(negedge clk);
      idx_by_hist = 1'b0;
      pred_addr = ADDR_W'(idx);
      #2;
   endtask

   // one resolve pulse; kinds: 1 = local right only, -1 = global right only, 0 agree-right, 2 agree-wrong
   task automatic resolve(input int idx, input int kind);
      @(negedge clk);
      res_idx = IDX_W'(idx);
      res_taken = 1'b1;
      case (kind)
         1:  begin res_loc_pred = 1'b1; res_glb_pred = 1'b0; end
         -1: begin res_loc_pred = 1'b0; res_glb_pred = 1'b1; end
         0:  begin res_loc_pred = 1'b1; res_glb_pred = 1'b1; end
         default: begin res_loc_pred = 1'b0; res_glb_pred = 1'b0; end
      endcase
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 64; i += 9) begin
         look(i);
         check("R3 reset counter selects global", pick_c, 0);
         check("R7 reset flags select global", pick_f, 0);
      end
   endtask

   task automatic t_index;
      @(negedge clk);
      pred_addr = 16'h5A2A; pred_hist = 12'h715; idx_by_hist = 1'b0; #2;
      check("R1 address index", idx_c, 6'h2A);
      idx_by_hist = 1'b1; #2;
      check("R1 history index", idx_c, 6'h15);
      idx_by_hist = 1'b0;
   endtask

   task automatic t_follow;
      resolve(5, 1);
      look(5); loc_pred = 1'b1; glb_pred = 1'b0; #1;
      check("R2 local chosen", pick_c, 1);
      check("R2 final follows local", fin_c, 1);
      look(6); #1;
      check("R2 final follows global", fin_c, 0);
      loc_pred = 1'b0; glb_pred = 1'b1; #1;
      check("R2 final follows global taken", fin_c, 1);
      loc_pred = 1'b0; glb_pred = 1'b0;
   endtask

   task automatic t_sat_up;
      for (int k = 0; k < 5; k++) resolve(7, 1);
      resolve(7, -1);
      look(7);
      check("R4 saturated at 11, one step down stays local", pick_c, 1);
      resolve(7, -1);
      look(7);
      check("R4 second step down reaches global", pick_c, 0);
   endtask

   task automatic t_sat_dn;
      for (int k = 0; k < 3; k++) resolve(8, -1);
      resolve(8, 1);
      look(8);
      check("R5 saturated at 00, one step up stays global", pick_c, 0);
      resolve(8, 1);
      look(8);
      check("R5 second step up reaches local", pick_c, 1);
   endtask

   task automatic t_agree;
      resolve(9, 1);
      for (int k = 0; k < 3; k++) resolve(9, 0);
      for (int k = 0; k < 3; k++) resolve(9, 2);
      look(9);
      check("R6 agreement keeps local", pick_c, 1);
      resolve(9, -1);
      look(9);
      check("R6 entry stayed 10 through agreement", pick_c, 0);
   endtask

   task automatic t_flags;
      resolve(10, 1);  look(10);
      check("R8 local right alone selects local", pick_f, 1);
      resolve(10, 0);  look(10);
      check("R8 both right selects global", pick_f, 0);
      resolve(10, 1);  look(10);
      check("R8 local right alone again", pick_f, 1);
      resolve(10, 2);  look(10);
      check("R8 both wrong selects global", pick_f, 0);
      resolve(10, 1);  resolve(10, -1); look(10);
      check("R8 global right selects global", pick_f, 0);
   endtask

   task automatic t_captured_idx;
      @(negedge clk);
      idx_by_hist = 1'b1; pred_hist = 12'd20; pred_addr = 16'd11;
      res_idx = 6'd11; res_loc_pred = 1'b1; res_glb_pred = 1'b0; res_taken = 1'b1;
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0; #2;
      check("R9 history-selected entry untouched", pick_c, 0);
      look(11);
      check("R9 entry at res_idx trained", pick_c, 1);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      idx_by_hist = 1'b0; pred_addr = 16'd12;
      res_idx = 6'd12; res_loc_pred = 1'b1; res_glb_pred = 1'b0; res_taken = 1'b1;
      res_valid = 1'b1; #2;
      check("R10 counter prediction sees old entry", pick_c, 0);
      check("R10 flags prediction sees old entry", pick_f, 0);
      @(posedge clk); #2;
      check("R10 counter update visible after edge", pick_c, 1);
      check("R10 flags update visible after edge", pick_f, 1);
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic t_idle;
      @(negedge clk);
      res_idx = 6'd13; res_loc_pred = 1'b1; res_glb_pred = 1'b0; res_taken = 1'b1;
      res_valid = 1'b0;
      repeat (4) @(negedge clk);
      look(13);
      check("R11 counter unchanged without strobe", pick_c, 0);
      check("R11 flags unchanged without strobe", pick_f, 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_follow();
      t_sat_up();
      t_sat_dn();
      t_agree();
      t_flags();
      t_captured_idx();
      t_same_cycle();
      t_idle();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule